// File: doc/BRIEF.md
# Record Length and Count Sequencer

This block is the control side of a compress/decompress datapath. It does not touch the data. It counts the bytes that the datapath moves and splits the stream into records. A local processor programs the record size and the number of records through a small register port, picks an operating mode and starts the transfer. The block then marks the last byte of every record and flags the end of the whole transfer. It raises an active-low interrupt for any status event that software has enabled.

The mode sets which data port takes input and which drives output:

- Both compression modes take input on port A and drive port B.
- All three decompression modes take input on port B and drive port A.

In the decompress-and-drop mode, the block withholds the pass qualifier for the first bytes of each record, up to a programmed offset. It then passes the rest of that record. A decode-error input from the decompressor is latched as a status event.

Top module: `rec_seq`

## Requirements
- R1: After reset the outputs are as follows:
  - `busy`, `done` and `rec_end` are 0, and `irq_n` is 1.
  - Every readable register returns 0.
  - The mode is compress (code 0), so `a_is_in`=1 and `b_is_in`=0.
- R2: The mode field is `wr_data[2:0]` of a write to address 2. The codes are: 0 compress, 1 compress pass-through, 2 decompress, 3 decompress pass-through, 4 decompress-and-drop.
  - Codes 0 and 1 give `a_is_in`=1, `b_is_in`=0. Codes 2 to 4 give `a_is_in`=0, `b_is_in`=1.
  - Codes 5 to 7 leave the mode unchanged.
  - A mode write while `busy` is 1 is ignored.
- R3: A write to address 2 with `wr_data[8]`=1 while idle starts a transfer. From the next clock edge, `busy`=1 and `done`=0. The same write while `busy` is 1 has no effect.
- R4: `rec_end` is high, in the same cycle as `byte_vld`, on the L-th byte of each record. L is the length at address 0, reloaded at each record start, and a length of 0 means 2^32 bytes.
- R5: After the `rec_end` of record C, `busy` falls and `done` rises at the next edge. C is the count at address 1, and a count of 0 means 2^32 records.
- R6: `pass_en` equals `byte_vld & busy`, with one exception. In mode 4, bytes whose index within the record (counting from 0) is below the offset at address 5 get `pass_en`=0. The index restarts at every record.
- R7: Status is at address 4. Bit 0 is record end, bit 1 is transfer done, and bit 2 is decode error. A decode error is `dec_err` with `busy` set, in mode 2 or 4.
  - Writing 1 to a bit clears it.
  - A new event in the same cycle as the clear keeps the bit set.
- R8: `irq_n` is 0 exactly when some status bit is set whose enable bit (same position, address 3) is also set.
- R9: Reads are combinational on `addr`:
  - Addresses 0, 1 and 5 return the length, count and offset.
  - Address 2 returns the mode, address 3 the enables and address 4 the status.
  - Address 6 returns the bytes left in the current record, and address 7 the records left.
- R10: `byte_vld` while idle produces no `rec_end` and no `pass_en`, and leaves the byte and record counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| byte_vld | input | 1 | One byte moves through the datapath this cycle |
| dec_err | input | 1 | Decoder reports a corrupt stream |
| a_is_in | output | 1 | Port A acts as input |
| b_is_in | output | 1 | Port B acts as input |
| pass_en | output | 1 | Current byte is to be forwarded |
| rec_end | output | 1 | Current byte ends a record |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A byte counter that is off by one moves `rec_end` by one byte. This shows at the very first record boundary. A wrong record counter moves the fall of `busy` by a whole record. A drop window keyed to a stale index gives a wrong `pass_en` on the first byte of the second record. The bench therefore sweeps small lengths, counts and offsets and compares every byte's qualifiers against arithmetic expectations. The remaining-count registers expose the counter state between bytes. This also covers the 2^32 encodings of a zero length or count.

// File: rtl/rec_seq_pkg.sv
package rec_seq_pkg;
    typedef enum logic [2:0] {
        M_COMP      = 3'd0,
        M_COMP_PT   = 3'd1,
        M_DEC       = 3'd2,
        M_DEC_PT    = 3'd3,
        M_DEC_DROP  = 3'd4
    } mode_e;

    localparam int A_LEN   = 0;
    localparam int A_CNT   = 1;
    localparam int A_CTRL  = 2;
    localparam int A_IEN   = 3;
    localparam int A_STS   = 4;
    localparam int A_OFF   = 5;
    localparam int A_BLEFT = 6;
    localparam int A_RLEFT = 7;

    localparam int START_BIT = 8;
    localparam int STS_W     = 3;
    localparam int S_EOR  = 0;
    localparam int S_DONE = 1;
    localparam int S_ERR  = 2;

    function automatic logic mode_valid(input logic [2:0] m);
        return m <= 3'd4;
    endfunction
endpackage

// File: rtl/rec_seq_regs.sv
module rec_seq_regs
    import rec_seq_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             busy,
    input  logic             set_eor,
    input  logic             set_done,
    input  logic             set_err,
    output logic [DW-1:0]    len_q,
    output logic [DW-1:0]    cnt_q,
    output logic [DW-1:0]    off_q,
    output mode_e            mode_q,
    output logic [STS_W-1:0] ien_q,
    output logic [STS_W-1:0] sts_q,
    output logic             start
);
    localparam logic [AW-1:0] LA_LEN  = AW'(A_LEN);
    localparam logic [AW-1:0] LA_CNT  = AW'(A_CNT);
    localparam logic [AW-1:0] LA_CTRL = AW'(A_CTRL);
    localparam logic [AW-1:0] LA_IEN  = AW'(A_IEN);
    localparam logic [AW-1:0] LA_STS  = AW'(A_STS);
    localparam logic [AW-1:0] LA_OFF  = AW'(A_OFF);

    typedef struct packed {
        logic [DW-1:0]    len;
        logic [DW-1:0]    cnt;
        logic [DW-1:0]    off;
        mode_e            mode;
        logic [STS_W-1:0] ien;
        logic [STS_W-1:0] sts;
    } regs_t;

    regs_t r_d, r_q;
    logic  start_d;

    always_comb begin
        r_d     = r_q;
        start_d = 1'b0;
        if (wr_en) begin
            if (addr == LA_LEN) r_d.len = wr_data;
            if (addr == LA_CNT) r_d.cnt = wr_data;
            if (addr == LA_OFF) r_d.off = wr_data;
            if (addr == LA_IEN) r_d.ien = wr_data[STS_W-1:0];
            if (addr == LA_STS) r_d.sts = r_q.sts & ~wr_data[STS_W-1:0];
            if (addr == LA_CTRL && !busy) begin
                if (mode_valid(wr_data[2:0])) r_d.mode = mode_e'(wr_data[2:0]);
                start_d = wr_data[START_BIT];
            end
        end
        // events win over a same-cycle clear
        if (set_eor)  r_d.sts[S_EOR]  = 1'b1;
        if (set_done) r_d.sts[S_DONE] = 1'b1;
        if (set_err)  r_d.sts[S_ERR]  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{len: '0, cnt: '0, off: '0, mode: M_COMP, ien: '0, sts: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign len_q  = r_q.len;
    assign cnt_q  = r_q.cnt;
    assign off_q  = r_q.off;
    assign mode_q = r_q.mode;
    assign ien_q  = r_q.ien;
    assign sts_q  = r_q.sts;
    assign start  = start_d;
endmodule

// File: rtl/rec_seq_cnt.sv
module rec_seq_cnt #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          byte_vld,
    input  logic [DW-1:0] len,
    input  logic [DW-1:0] cnt,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] byte_left,
    output logic [DW-1:0] rec_left,
    output logic [DW-1:0] pos,
    output logic          rec_end,
    output logic          xfer_end
);
    localparam logic [DW-1:0] ONE = DW'(1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [DW-1:0] byte_left;
        logic [DW-1:0] rec_left;
        logic [DW-1:0] pos;
    } cnt_t;

    cnt_t c_d, c_q;
    logic end_d, last_d;

    always_comb begin
        c_d    = c_q;
        end_d  = c_q.busy && byte_vld && (c_q.byte_left == ONE);
        last_d = end_d && (c_q.rec_left == ONE);
        if (start && !c_q.busy) begin
            c_d.busy      = 1'b1;
            c_d.done      = 1'b0;
            c_d.byte_left = len;
            c_d.rec_left  = cnt;
            c_d.pos       = '0;
        end else if (c_q.busy && byte_vld) begin
            if (last_d) begin
                c_d.busy      = 1'b0;
                c_d.done      = 1'b1;
                c_d.byte_left = '0;
                c_d.rec_left  = '0;
                c_d.pos       = '0;
            end else if (end_d) begin
                c_d.byte_left = len;
                c_d.rec_left  = c_q.rec_left - ONE;
                c_d.pos       = '0;
            end else begin
                c_d.byte_left = c_q.byte_left - ONE;
                c_d.pos       = c_q.pos + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy      = c_q.busy;
    assign done      = c_q.done;
    assign byte_left = c_q.byte_left;
    assign rec_left  = c_q.rec_left;
    assign pos       = c_q.pos;
    assign rec_end   = end_d;
    assign xfer_end  = last_d;
endmodule

// File: rtl/rec_seq_win.sv
module rec_seq_win
    import rec_seq_pkg::*;
#(
    parameter int DW = 32
) (
    input  mode_e         mode,
    input  logic [DW-1:0] off,
    input  logic [DW-1:0] pos,
    input  logic          busy,
    input  logic          byte_vld,
    input  logic          dec_err,
    output logic          a_is_in,
    output logic          b_is_in,
    output logic          pass_en,
    output logic          err_evt
);
    logic comp_side, drop_win, decoding;

    always_comb begin
        comp_side = (mode == M_COMP) || (mode == M_COMP_PT);
        decoding  = (mode == M_DEC) || (mode == M_DEC_DROP);
        drop_win  = (mode == M_DEC_DROP) && (pos < off);
        a_is_in   = comp_side;
        b_is_in   = !comp_side;
        pass_en   = busy && byte_vld && !drop_win;
        err_evt   = busy && dec_err && decoding;
    end
endmodule

// File: rtl/rec_seq.sv
module rec_seq
    import rec_seq_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          byte_vld,
    input  logic          dec_err,
    output logic          a_is_in,
    output logic          b_is_in,
    output logic          pass_en,
    output logic          rec_end,
    output logic          busy,
    output logic          done,
    output logic          irq_n
);
    localparam logic [AW-1:0] LA_LEN   = AW'(A_LEN);
    localparam logic [AW-1:0] LA_CNT   = AW'(A_CNT);
    localparam logic [AW-1:0] LA_CTRL  = AW'(A_CTRL);
    localparam logic [AW-1:0] LA_IEN   = AW'(A_IEN);
    localparam logic [AW-1:0] LA_STS   = AW'(A_STS);
    localparam logic [AW-1:0] LA_OFF   = AW'(A_OFF);
    localparam logic [AW-1:0] LA_BLEFT = AW'(A_BLEFT);
    localparam logic [AW-1:0] LA_RLEFT = AW'(A_RLEFT);

    logic [DW-1:0]    len_q, cnt_q, off_q;
    mode_e            mode_q;
    logic [STS_W-1:0] ien_q, sts_q;
    logic             start, xfer_end, err_evt;
    logic [DW-1:0]    byte_left, rec_left, pos;

    rec_seq_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .busy(busy), .set_eor(rec_end), .set_done(xfer_end), .set_err(err_evt),
        .len_q(len_q), .cnt_q(cnt_q), .off_q(off_q), .mode_q(mode_q),
        .ien_q(ien_q), .sts_q(sts_q), .start(start)
    );

    rec_seq_cnt #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_vld(byte_vld),
        .len(len_q), .cnt(cnt_q), .busy(busy), .done(done),
        .byte_left(byte_left), .rec_left(rec_left), .pos(pos),
        .rec_end(rec_end), .xfer_end(xfer_end)
    );

    rec_seq_win #(.DW(DW)) u_win (
        .mode(mode_q), .off(off_q), .pos(pos), .busy(busy),
        .byte_vld(byte_vld), .dec_err(dec_err),
        .a_is_in(a_is_in), .b_is_in(b_is_in), .pass_en(pass_en), .err_evt(err_evt)
    );

    always_comb begin
        rd_data = '0;
        if (addr == LA_LEN)   rd_data = len_q;
        if (addr == LA_CNT)   rd_data = cnt_q;
        if (addr == LA_CTRL)  rd_data = DW'(mode_q);
        if (addr == LA_IEN)   rd_data = DW'(ien_q);
        if (addr == LA_STS)   rd_data = DW'(sts_q);
        if (addr == LA_OFF)   rd_data = off_q;
        if (addr == LA_BLEFT) rd_data = byte_left;
        if (addr == LA_RLEFT) rd_data = rec_left;
    end

    assign irq_n = ~|(sts_q & ien_q);
endmodule

// File: rtl/rec_seq_chk.sv
module rec_seq_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          rec_end,
    input logic          byte_vld,
    input logic          pass_en,
    input logic          a_is_in,
    input logic          b_is_in,
    input logic          irq_n,
    input logic [DW-1:0] rec_left,
    input logic [2:0]    ien,
    input logic [2:0]    sts
);
    a_r4_end_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rec_end |-> busy);
    a_r5_last_end_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_end && rec_left == DW'(1)) |=> (!busy && done));
    a_r5_more_records: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_end && rec_left != DW'(1)) |=> busy);
    a_r6_pass_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        pass_en |-> (byte_vld && busy));
    a_r2_dirs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(a_is_in) && $stable(b_is_in)));
    a_r2_dirs_opposite: assert property (@(posedge clk) disable iff (!rst_n)
        a_is_in != b_is_in);
    a_r8_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sts[1]) && ien[1]) |-> !irq_n);
endmodule

bind rec_seq rec_seq_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rec_end(rec_end),
    .byte_vld(byte_vld), .pass_en(pass_en), .a_is_in(a_is_in), .b_is_in(b_is_in),
    .irq_n(irq_n), .rec_left(rec_left), .ien(ien_q), .sts(sts_q)
);

// File: tb/tb_rec_seq.sv
`timescale 1ns/1ps
module tb_rec_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        byte_vld = 1'b0;
    logic        dec_err = 1'b0;
    logic        a_is_in, b_is_in, pass_en, rec_end, busy, done, irq_n;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    rec_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .byte_vld(byte_vld), .dec_err(dec_err),
        .a_is_in(a_is_in), .b_is_in(b_is_in), .pass_en(pass_en), .rec_end(rec_end),
        .busy(busy), .done(done), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1 chk(req, rd_data, exp);
    endtask

    // one transfer, every byte's qualifiers predicted arithmetically
    task automatic run_xfer(input int mode, input int len, input int cnt, input int off);
        wr(3'd0, len); wr(3'd1, cnt); wr(3'd5, off); wr(3'd4, 32'h7);
        wr(3'd2, 32'h100 | mode);
        @(negedge clk); #1 chk("R3 busy after start", busy, 1);
        chk("R3 done cleared", done, 0);
        for (int r = 0; r < cnt; r++) begin
            for (int i = 0; i < len; i++) begin
                @(negedge clk);
                byte_vld = 1'b1;
                #1;
                chk("R4 rec_end", rec_end, (i == len - 1) ? 1 : 0);
                chk("R6 pass_en", pass_en, (mode != 4 || i >= off) ? 1 : 0);
            end
        end
        @(negedge clk);
        byte_vld = 1'b0;
        #1 chk("R5 busy fell", busy, 0);
        chk("R5 done", done, 1);
        chk("R8 irq masked", irq_n, 1);
        rd_chk("R7 status eor+done", 3'd4, 32'h3);
    endtask

    int cur;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 irq_n", irq_n, 1);
        chk("R1 a_is_in", a_is_in, 1); chk("R1 b_is_in", b_is_in, 0);
        chk("R1 rec_end", rec_end, 0);
        for (int a = 0; a < 8; a++) rd_chk("R1 regs zero", 3'(a), 0);

        // R10 idle bytes ignored
        wr(3'd2, 4);
        @(negedge clk); byte_vld = 1'b1; #1;
        chk("R10 idle rec_end", rec_end, 0); chk("R10 idle pass_en", pass_en, 0);
        @(negedge clk); byte_vld = 1'b0;
        rd_chk("R10 bytes left unchanged", 3'd6, 0);
        rd_chk("R10 records left unchanged", 3'd7, 0);

        // R2 mode codes and directions
        cur = 4;
        for (int m = 0; m < 8; m++) begin
            wr(3'd2, m);
            if (m <= 4) cur = m;
            @(negedge clk); #1;
            chk("R2 a_is_in", a_is_in, (cur <= 1) ? 1 : 0);
            chk("R2 b_is_in", b_is_in, (cur <= 1) ? 0 : 1);
            rd_chk("R2 mode readback", 3'd2, cur);
        end

        // R4 R5 R6 sweeps
        for (int len = 1; len <= 4; len++)
            for (int cnt = 1; cnt <= 3; cnt++) begin
                run_xfer(0, len, cnt, 0);
                for (int off = 0; off <= len + 1; off++) run_xfer(4, len, cnt, off);
            end

        // R9 R4 R3: zero length means 2^32 bytes
        do_reset();
        wr(3'd0, 0); wr(3'd1, 2); wr(3'd2, 32'h100);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); byte_vld = 1'b1; #1;
            chk("R4 no end in 2^32 record", rec_end, 0);
        end
        @(negedge clk); byte_vld = 1'b0;
        rd_chk("R9 bytes left", 3'd6, 32'hFFFF_FFFD);
        rd_chk("R9 records left", 3'd7, 2);
        rd_chk("R9 length readback", 3'd0, 0);
        wr(3'd2, 32'h102);
        @(negedge clk); #1;
        chk("R3 restart while busy ignored", a_is_in, 1);
        rd_chk("R3 counters kept", 3'd6, 32'hFFFF_FFFD);
        chk("R2 mode write while busy ignored", a_is_in, 1);

        // R5 zero count means 2^32 records
        do_reset();
        wr(3'd0, 1); wr(3'd1, 0); wr(3'd2, 32'h100);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); byte_vld = 1'b1; #1;
            chk("R4 each byte ends record", rec_end, 1);
        end
        @(negedge clk); byte_vld = 1'b0; #1;
        chk("R5 still busy", busy, 1);
        rd_chk("R5 records left wrapped", 3'd7, 32'hFFFF_FFFD);

        // R7 R8 status and interrupt
        do_reset();
        wr(3'd0, 4); wr(3'd1, 1); wr(3'd2, 32'h102);
        @(negedge clk); byte_vld = 1'b1; dec_err = 1'b1;
        @(negedge clk); byte_vld = 1'b0; dec_err = 1'b0;
        rd_chk("R7 error bit", 3'd4, 32'h4);
        chk("R8 irq off when disabled", irq_n, 1);
        wr(3'd3, 32'h4);
        @(negedge clk); #1 chk("R8 irq on error", irq_n, 0);
        wr(3'd4, 32'h4);
        @(negedge clk); #1 chk("R8 irq off after clear", irq_n, 1);
        rd_chk("R7 W1C cleared", 3'd4, 0);
        // set wins over same-cycle clear
        @(negedge clk);
        byte_vld = 1'b1; dec_err = 1'b1; wr_en = 1'b1; addr = 3'd4; wr_data = 32'h4;
        @(negedge clk);
        byte_vld = 1'b0; dec_err = 1'b0; wr_en = 1'b0;
        rd_chk("R7 set beats clear", 3'd4, 32'h4);
        wr(3'd4, 32'h7); wr(3'd3, 32'h2);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); byte_vld = 1'b1;
        end
        @(negedge clk); byte_vld = 1'b0; #1;
        chk("R8 irq on done", irq_n, 0);
        rd_chk("R7 done+eor", 3'd4, 32'h3);

        // R7 no decode error in pass-through
        do_reset();
        wr(3'd0, 2); wr(3'd1, 1); wr(3'd2, 32'h103);
        @(negedge clk); byte_vld = 1'b1; dec_err = 1'b1;
        @(negedge clk); byte_vld = 1'b0; dec_err = 1'b0;
        rd_chk("R7 no error in pass-through", 3'd4, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule